// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Generator

This block produces the bus-side waveforms of a single machine cycle for a small 8-bit processor. The bus has a 16-bit address whose low byte shares eight pins with the data, one after the other in time. A requester gives a cycle kind (opcode fetch, memory read, memory write, I/O read or I/O write), an address, write data and, for fetches, a choice between a short and a long fetch. The block then steps through the T-states. It drives the three status lines, the address-latch strobe, the active-low read and write strobes, the upper address byte and the shared low byte. On a read it captures the returned byte, and it flags completion with a one-cycle pulse.

The block runs on a clock at twice the T-state rate. Each T-state is two clock cycles: a high half and a low half. The block brings out a T-state clock with 50% duty while a cycle is in progress. All bus outputs are decoded from the sequencer state, so each one changes right after the clock edge that moves the sequencer.

Top module: `mcg_cycle_gen`

## Requirements
- R1: The status lines {io_m_o, s1_o, s0_o} take the value for the accepted kind: fetch (kind_i=0) 0,1,1; memory read (1) 0,1,0; memory write (2) 0,0,1; I/O read (3) 1,1,0; I/O write (4) 1,0,1. The value appears from the first half of T1 onward.
- R2: After reset, and between cycles, both strobes are high, ale_o is low and ad_oe_o is low. The status lines read 0,0,0 after reset and otherwise keep the value of the last cycle.
- R3: A read, write, I/O read or I/O write lasts 3 T-states. A fetch lasts 4 T-states, or 6 when long_fetch_i=1. busy_o is high for exactly 2 clocks per T-state, and done_o is high for the single clock right after busy_o falls.
- R4: ale_o is high only in the first half of T1. Throughout T1, addr_hi_o carries address bits 15:8 and ad_o carries bits 7:0 with ad_oe_o high.
- R5: In I/O cycles, address bits 7:0 (the port number) appear on both addr_hi_o and ad_o in T1, and addr_hi_o keeps that value for the whole cycle.
- R6: In fetch, memory read and I/O read, rd_n_o is low exactly in T2 and T3, ad_oe_o is low in T2 and T3, and wr_n_o stays high.
- R7: In memory write and I/O write, wr_n_o is low exactly in T2 and T3, ad_o carries the write data with ad_oe_o high in T2 and T3, and rd_n_o stays high.
- R8: rdata_o takes the value on rdata_i at the clock edge that ends T3 of a read-type cycle. It is left unchanged by write cycles.
- R9: start_i is acted on only while idle and only for a kind_i code from 0 to 4. A start raised while busy, or one with codes 5 to 7, changes neither the running cycle nor the status lines.
- R10: While busy, tclk_o is high in the first half and low in the second half of every T-state. It is low while idle.
- R11: In the T-states after T3 of a fetch, both strobes are high and ad_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a machine cycle |
| kind_i | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| addr_i | input | 16 | Memory address, or port number in bits 7:0 |
| wdata_i | input | 8 | Byte to write in write-type cycles |
| long_fetch_i | input | 1 | Selects the 6 T-state fetch |
| rdata_i | input | 8 | Byte present on the shared bus from outside |
| io_m_o | output | 1 | Status: I/O (1) or memory (0) |
| s1_o | output | 1 | Status line 1 |
| s0_o | output | 1 | Status line 0 |
| ale_o | output | 1 | Address-latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| addr_hi_o | output | 8 | Upper address lines |
| ad_o | output | 8 | Value driven on the shared address/data bus |
| ad_oe_o | output | 1 | Output enable for the shared bus |
| tclk_o | output | 1 | T-state clock |
| busy_o | output | 1 | A machine cycle is in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Last byte captured by a read-type cycle |

## Verification
A wrong T-state or phase in the sequencer shows up on the very next sample. The strobes, ale_o, ad_oe_o and tclk_o are all decoded directly from that state, so any of them can go wrong there, and a miscounted cycle length moves the fall of busy_o and the done_o pulse. A wrong latched request shows in T1 as the wrong status pattern or the wrong address halves. A wrong capture edge for read data shows only once busy_o drops, as a wrong rdata_o. The bench makes that visible by putting the expected byte on rdata_i during T3 only.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4
  } cyc_kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } status_t;

  localparam int TS_W = 3;
  localparam int SHORT_FETCH_T = 4;
  localparam int LONG_FETCH_T = 6;
  localparam int BUS_T = 3;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic status_t status_of(input cyc_kind_e k);
    status_t s;
    case (k)
      CYC_FETCH: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      CYC_MRD:   s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      CYC_MWR:   s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      CYC_IORD:  s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      default:   s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
    endcase
    return s;
  endfunction

  function automatic logic [TS_W-1:0] tcount_of(input cyc_kind_e k, input logic long_f);
    if (k == CYC_FETCH) return long_f ? TS_W'(LONG_FETCH_T) : TS_W'(SHORT_FETCH_T);
    return TS_W'(BUS_T);
  endfunction

  function automatic logic is_rd(input cyc_kind_e k);
    return (k == CYC_FETCH) || (k == CYC_MRD) || (k == CYC_IORD);
  endfunction

  function automatic logic is_wr(input cyc_kind_e k);
    return (k == CYC_MWR) || (k == CYC_IOWR);
  endfunction

  function automatic logic is_io(input cyc_kind_e k);
    return (k == CYC_IORD) || (k == CYC_IOWR);
  endfunction

endpackage

// File: rtl/mcg_tseq.sv
module mcg_tseq
  import mcg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            kind_ok_i,
  input  logic [TS_W-1:0] len_i,
  output logic            accept_o,
  output logic            busy_o,
  output logic [TS_W-1:0] tstate_o,
  output logic            phase_o,
  output logic            last_half_o,
  output logic            done_o
);

  logic [TS_W-1:0] len_q;

  assign accept_o    = start_i && kind_ok_i && !busy_o;
  assign last_half_o = busy_o && phase_o && (tstate_o == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      tstate_o <= TS_W'(1);
      phase_o  <= 1'b0;
      len_q    <= TS_W'(BUS_T);
      done_o   <= 1'b0;
    end else begin
      done_o <= last_half_o;
      if (accept_o) begin
        busy_o   <= 1'b1;
        tstate_o <= TS_W'(1);
        phase_o  <= 1'b0;
        len_q    <= len_i;
      end else if (busy_o) begin
        phase_o <= !phase_o;
        if (phase_o) begin
          if (last_half_o) busy_o <= 1'b0;
          else tstate_o <= tstate_o + TS_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/mcg_req_reg.sv
module mcg_req_reg
  import mcg_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output cyc_kind_e     kind_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output status_t       status_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= CYC_FETCH;
      addr_q   <= '0;
      wdata_q  <= '0;
      status_q <= '0;
    end else if (accept_i) begin
      kind_q   <= cyc_kind_e'(kind_i);
      addr_q   <= addr_i;
      wdata_q  <= wdata_i;
      status_q <= status_of(cyc_kind_e'(kind_i));
    end
  end

endmodule

// File: rtl/mcg_bus_drv.sv
module mcg_bus_drv
  import mcg_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            busy_i,
  input  logic [TS_W-1:0] tstate_i,
  input  logic            phase_i,
  input  cyc_kind_e       kind_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   rdata_i,
  output logic            ale_o,
  output logic            rd_n_o,
  output logic            wr_n_o,
  output logic [DW-1:0]   addr_hi_o,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic            tclk_o,
  output logic            sample_o,
  output logic [DW-1:0]   rdata_o
);

  logic in_t1, strobe_win;
  logic [DW-1:0] lo_addr;

  assign in_t1      = busy_i && (tstate_i == TS_W'(1));
  assign strobe_win = busy_i && ((tstate_i == TS_W'(2)) || (tstate_i == TS_W'(3)));
  assign sample_o   = busy_i && is_rd(kind_i) && (tstate_i == TS_W'(3)) && phase_i;

  assign lo_addr   = addr_i[DW-1:0];
  assign addr_hi_o = is_io(kind_i) ? lo_addr : addr_i[AW-1:DW];

  always_comb begin
    ale_o   = in_t1 && !phase_i;
    tclk_o  = busy_i && !phase_i;
    rd_n_o  = !(strobe_win && is_rd(kind_i));
    wr_n_o  = !(strobe_win && is_wr(kind_i));
    ad_oe_o = 1'b0;
    ad_o    = '0;
    if (in_t1) begin
      ad_oe_o = 1'b1;
      ad_o    = lo_addr;
    end else if (strobe_win && is_wr(kind_i)) begin
      ad_oe_o = 1'b1;
      ad_o    = wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (sample_o) rdata_o <= rdata_i;
  end

endmodule

// File: rtl/mcg_cycle_gen.sv
module mcg_cycle_gen
  import mcg_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          long_fetch_i,
  input  logic [DW-1:0] rdata_i,
  output logic          io_m_o,
  output logic          s1_o,
  output logic          s0_o,
  output logic          ale_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic [DW-1:0] addr_hi_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          tclk_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);

  logic            accept_w;
  logic            last_half_w;
  logic            sample_w;
  logic            phase_w;
  logic [TS_W-1:0] tstate_w;
  logic [TS_W-1:0] len_w;
  cyc_kind_e       kind_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  status_t         status_q;

  assign len_w = tcount_of(cyc_kind_e'(kind_i), long_fetch_i);

  mcg_tseq seq_i (
    .clk(clk), .rst(rst), .start_i(start_i), .kind_ok_i(kind_ok(kind_i)),
    .len_i(len_w), .accept_o(accept_w), .busy_o(busy_o), .tstate_o(tstate_w),
    .phase_o(phase_w), .last_half_o(last_half_w), .done_o(done_o)
  );

  mcg_req_reg #(.DW(DW)) req_i (
    .clk(clk), .rst(rst), .accept_i(accept_w), .kind_i(kind_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .kind_q(kind_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .status_q(status_q)
  );

  mcg_bus_drv #(.DW(DW)) drv_i (
    .clk(clk), .rst(rst), .busy_i(busy_o), .tstate_i(tstate_w),
    .phase_i(phase_w), .kind_i(kind_q), .addr_i(addr_q), .wdata_i(wdata_q),
    .rdata_i(rdata_i), .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .addr_hi_o(addr_hi_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .tclk_o(tclk_o),
    .sample_o(sample_w), .rdata_o(rdata_o)
  );

  assign io_m_o = status_q.io_m;
  assign s1_o   = status_q.s1;
  assign s0_o   = status_q.s0;

endmodule

// File: rtl/mcg_checker.sv
module mcg_checker (
  input logic clk,
  input logic rst,
  input logic accept_w,
  input logic sample_w,
  input logic busy_o,
  input logic done_o,
  input logic ale_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic ad_oe_o,
  input logic tclk_o,
  input logic io_m_o,
  input logic s1_o,
  input logic s0_o
);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    rd_n_o || wr_n_o);

  assert_ale_bus_R4: assert property (@(posedge clk) disable iff (rst)
    ale_o |-> (ad_oe_o && rd_n_o && wr_n_o));

  assert_ale_half_R4: assert property (@(posedge clk) disable iff (rst)
    ale_o |=> !ale_o);

  assert_rd_release_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> !ad_oe_o);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (rd_n_o && wr_n_o && !ale_o && !ad_oe_o));

  assert_status_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !accept_w |=> $stable({io_m_o, s1_o, s0_o}));

  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (rst)
    accept_w |-> !busy_o);

  assert_done_end_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_sample_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    sample_w |-> !rd_n_o);

  assert_tclk_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && tclk_o) |=> !tclk_o);

  assert_tclk_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !tclk_o);

endmodule

bind mcg_cycle_gen mcg_checker chk_i (
  .clk(clk), .rst(rst), .accept_w(accept_w), .sample_w(sample_w),
  .busy_o(busy_o), .done_o(done_o), .ale_o(ale_o), .rd_n_o(rd_n_o),
  .wr_n_o(wr_n_o), .ad_oe_o(ad_oe_o), .tclk_o(tclk_o), .io_m_o(io_m_o),
  .s1_o(s1_o), .s0_o(s0_o)
);

// File: tb/mcg_cycle_gen_tb.sv
module mcg_cycle_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [2:0] kind_i;
  logic [15:0] addr_i;
  logic [7:0] wdata_i;
  logic       long_fetch_i;
  logic [7:0] rdata_i;
  logic       io_m_o, s1_o, s0_o, ale_o, rd_n_o, wr_n_o, ad_oe_o, tclk_o, busy_o, done_o;
  logic [7:0] addr_hi_o, ad_o, rdata_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] exp_rdata = 8'h00;
  logic [2:0] exp_status = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcg_cycle_gen dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .long_fetch_i(long_fetch_i), .rdata_i(rdata_i),
    .io_m_o(io_m_o), .s1_o(s1_o), .s0_o(s0_o), .ale_o(ale_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .addr_hi_o(addr_hi_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .tclk_o(tclk_o), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] status_for(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  task automatic check_idle(input string req);
    check(!busy_o && rd_n_o && wr_n_o && !ale_o && !ad_oe_o && !tclk_o, req,
          "idle bus {busy,rd_n,wr_n,ale,oe,tclk}",
          {26'd0, busy_o, rd_n_o, wr_n_o, ale_o, ad_oe_o, tclk_o}, 32'b011000);
    check({io_m_o, s1_o, s0_o} == exp_status, req, "idle status",
          {29'd0, io_m_o, s1_o, s0_o}, {29'd0, exp_status});
  endtask

  // One machine cycle; poke keeps start_i high with another kind while busy (R9).
  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                           input logic lf, input logic [7:0] rv, input logic poke);
    int len;
    logic rdk, wrk, iok;
    logic [7:0] hi_exp;
    len = (k == 3'd0) ? (lf ? 6 : 4) : 3;
    rdk = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    wrk = (k == 3'd2) || (k == 3'd4);
    iok = (k == 3'd3) || (k == 3'd4);
    hi_exp = iok ? a[7:0] : a[15:8];
    @(negedge clk);
    start_i = 1'b1; kind_i = k; addr_i = a; wdata_i = wd; long_fetch_i = lf; rdata_i = ~rv;
    for (int j = 0; j < 2 * len; j++) begin
      int t;
      int ph;
      logic ale_e, oe_e, rd_e, wr_e;
      logic [7:0] ad_e;
      @(negedge clk);
      t = j / 2 + 1;
      ph = j % 2;
      if (poke) begin
        start_i = (j < 2 * len - 1); kind_i = 3'd4; addr_i = 16'hFFFF; long_fetch_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      rdata_i = (t == 3) ? rv : ~rv;
      ale_e = (t == 1) && (ph == 0);
      oe_e  = (t == 1) || (wrk && (t == 2 || t == 3));
      rd_e  = !(rdk && (t == 2 || t == 3));
      wr_e  = !(wrk && (t == 2 || t == 3));
      ad_e  = (t == 1) ? a[7:0] : wd;
      check(busy_o && !done_o, "R3", "busy during cycle", {30'd0, busy_o, done_o}, 32'b10);
      check(tclk_o == (ph == 0), "R10", "tclk phase", {31'd0, tclk_o}, {31'd0, ph == 0});
      check(ale_o == ale_e, "R4", "ale", {31'd0, ale_o}, {31'd0, ale_e});
      check(addr_hi_o == hi_exp, iok ? "R5" : "R4", "upper address", {24'd0, addr_hi_o}, {24'd0, hi_exp});
      check(ad_oe_o == oe_e, t > 3 ? "R11" : (wrk ? "R7" : "R6"), "bus enable",
            {31'd0, ad_oe_o}, {31'd0, oe_e});
      if (oe_e) check(ad_o == ad_e, t == 1 ? (iok ? "R5" : "R4") : "R7", "bus value",
                      {24'd0, ad_o}, {24'd0, ad_e});
      check(rd_n_o == rd_e, t > 3 ? "R11" : "R6", "rd_n", {31'd0, rd_n_o}, {31'd0, rd_e});
      check(wr_n_o == wr_e, t > 3 ? "R11" : "R7", "wr_n", {31'd0, wr_n_o}, {31'd0, wr_e});
      check({io_m_o, s1_o, s0_o} == status_for(k), poke ? "R9" : "R1", "status",
            {29'd0, io_m_o, s1_o, s0_o}, {29'd0, status_for(k)});
    end
    @(negedge clk);
    start_i = 1'b0;
    if (rdk) exp_rdata = rv;
    exp_status = status_for(k);
    check(done_o && !busy_o, "R3", "done pulse at end", {30'd0, busy_o, done_o}, 32'b01);
    check(rdata_o == exp_rdata, "R8", "captured read data", {24'd0, rdata_o}, {24'd0, exp_rdata});
    @(negedge clk);
    check(!done_o, "R3", "done falls", {31'd0, done_o}, 32'd0);
    check_idle("R2");
  endtask

  task automatic test_reset();
    rst = 1'b1; start_i = 1'b0; kind_i = 3'd0; addr_i = '0; wdata_i = '0;
    long_fetch_i = 1'b0; rdata_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R2");
    check(rdata_o == 8'h00 && !done_o, "R2", "reset rdata/done", {23'd0, done_o, rdata_o}, 32'd0);
  endtask

  task automatic test_bad_kind();
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      start_i = 1'b1; kind_i = 3'(k);
      @(negedge clk);
      start_i = 1'b0;
      check(!busy_o, "R9", "undefined kind ignored", {31'd0, busy_o}, 32'd0);
      check_idle("R9");
    end
  endtask

  task automatic test_hold_between();
    repeat (5) begin
      @(negedge clk);
      check_idle("R2");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    test_reset();
    run_cycle(3'd0, 16'h5000, 8'h00, 1'b0, 8'h47, 1'b0);
    run_cycle(3'd0, 16'h1234, 8'h00, 1'b1, 8'hCD, 1'b0);
    run_cycle(3'd1, 16'hA55A, 8'h00, 1'b0, 8'h3C, 1'b0);
    run_cycle(3'd2, 16'hBEEF, 8'h96, 1'b1, 8'h11, 1'b0);
    test_hold_between();
    run_cycle(3'd3, 16'hC07E, 8'h00, 1'b0, 8'hE1, 1'b0);
    run_cycle(3'd4, 16'h0381, 8'h5A, 1'b0, 8'h22, 1'b0);
    run_cycle(3'd1, 16'h2000, 8'h00, 1'b0, 8'h88, 1'b1);
    test_bad_kind();
    run_cycle(3'd0, 16'h003E, 8'h00, 1'b1, 8'hF0, 1'b1);
    test_hold_between();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule